// File: doc/BRIEF.md
# Fiber PHY Basic Control Register

This block holds the 16-bit basic control word of a 100 Mbps fiber Ethernet PHY. Management software writes and reads it through a parallel read/write strobe port that sits behind the serial management framing logic. The writable controls are loopback, power-down, isolate, duplex and collision test. They go straight to the datapath as level outputs. From them the block also derives enables for the line circuits, the MII data path and collision detection.

Two timed sequences run on one shared down-counter. A soft reset is started by writing the top bit. It restores every control to its default and pulses a clear strobe for the status registers. The top bit reads as 1 for the whole interval, and other writes are refused until it ends. Leaving power-down starts a power-up interval instead. It pulses an error-clear strobe and keeps the line and MII disabled until the interval ends. Both intervals last `TIMER_CYCLES` clocks, which defaults to 500 ms at 100 MHz. The isolate control defaults to 1 only when the strapped PHY address is zero.

Top module: `phy_ctrl_reg`

## Requirements
- R1: After hard reset the word reads 0x2000 when `phyAddr` is nonzero and 0x2400 when `phyAddr` is zero, because isolate (bit 10) defaults to 1 only for address zero.
- R2: An accepted write with bit 15 set starts a soft reset. `busy` and read bit 15 are 1 for exactly `TIMER_CYCLES` cycles, starting the cycle after the write. All writable controls return to their defaults and the data bits of that write are discarded. Bit 15 then reads 0.
- R3: Any write made while a soft reset is running leaves the stored controls unchanged.
- R4: Bit 13 always reads 1. Bits 12, 9 and 6..0 always read 0, whatever was written to them.
- R5: `mgmtRdData` shows the live word in the same cycle that `mgmtRdEn` is high, and is 0 when `mgmtRdEn` is low.
- R6: A write with bit 15 clear stores bit 14 (loopback), 11 (power-down), 10 (isolate), 8 (full duplex, 1 = full) and 7 (collision test). These drive `loopbackEn`, `powerDownEn`, `isolateEn`, `fullDuplexEn` and `colTestEn` from the next cycle.
- R7: While power-down is set, `lineEnable`, `miiEnable` and `colDetectEn` are 0. Clearing power-down starts a power-up interval of `TIMER_CYCLES` cycles. During that interval `busy` is 1 and the three enables stay 0, and they return when it ends.
- R8: `statusClear` is a single-cycle pulse in the first cycle of a soft reset. `errorClear` is a single-cycle pulse in the first cycle of a power-up interval.
- R9: With loopback set, `lineEnable` is 0. `colDetectEn` is then 0 unless collision test is also set.
- R10: With isolate set, `miiEnable` is 0 while `lineEnable` is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low hard reset |
| phyAddr | input | ADDR_W | Strapped PHY address, used for the isolate default |
| mgmtWrEn | input | 1 | Write strobe from management framing |
| mgmtWrData | input | 16 | Write data |
| mgmtRdEn | input | 1 | Read strobe |
| mgmtRdData | output | 16 | Live register word while reading, else 0 |
| busy | output | 1 | A soft reset or power-up interval is running |
| loopbackEn | output | 1 | Loopback control |
| powerDownEn | output | 1 | Power-down control |
| isolateEn | output | 1 | Isolate control |
| fullDuplexEn | output | 1 | 1 = full duplex, 0 = half duplex |
| colTestEn | output | 1 | Collision signal test control |
| lineEnable | output | 1 | Transmit/receive line circuits enabled |
| miiEnable | output | 1 | MII data signals enabled |
| colDetectEn | output | 1 | Collision detection enabled |
| statusClear | output | 1 | One-cycle pulse that clears the status registers |
| errorClear | output | 1 | One-cycle pulse that clears error conditions |

## Verification
The bench builds the block with `TIMER_CYCLES` = 6 and `ADDR_W` = 5. The short interval lets every cycle of both sequences be sampled. With it, the first and last busy cycles, the strobe pulses and the write lockout all fit into a few dozen clocks. The narrow address allows a hard-reset sweep over all 32 strap values. Every 16-bit pattern with bit 15 clear is also written and read back, which covers every stored and fixed bit arithmetically.

// File: rtl/phyctl_pkg.sv
package phyctl_pkg;
  localparam int REG_W = 16;
  // bit positions decoded by the management side
  localparam int B_RESET   = 15;
  localparam int B_LOOP    = 14;
  localparam int B_PDOWN   = 11;
  localparam int B_ISOLATE = 10;
  localparam int B_DUPLEX  = 8;
  localparam int B_COLTEST = 7;
  localparam logic [REG_W-1:0] WR_MASK  = 16'h4D80;
  localparam logic [REG_W-1:0] ONE_MASK = 16'h2000;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_RESET   = 2'd1,
    SEQ_POWERUP = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic applyDefaults;
    logic takeWrite;
    logic resetActive;
    logic seqActive;
  } regCmd_t;
endpackage

// File: rtl/phyctl_seq.sv
module phyctl_seq
  import phyctl_pkg::*;
#(
  parameter int TIMER_CYCLES = 50_000_000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrEn,
  input  logic    wrResetBit,
  input  logic    wrPdBit,
  input  logic    pdNow,
  output regCmd_t cmd,
  output logic    resetActive,
  output logic    powerUpActive,
  output logic    statusClear,
  output logic    errorClear
);
  localparam int CNT_W = (TIMER_CYCLES > 1) ? $clog2(TIMER_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TIMER_CYCLES - 1);

  seqState_t        stateQ;
  logic [CNT_W-1:0] cntQ;
  logic             accept;
  logic             startReset;
  logic             startPowerUp;
  logic             cancelPowerUp;
  logic             timerDone;

  assign accept        = wrEn && (stateQ != SEQ_RESET);
  assign startReset    = accept && wrResetBit;
  assign startPowerUp  = accept && !wrResetBit && pdNow && !wrPdBit;
  assign cancelPowerUp = accept && !wrResetBit && wrPdBit && (stateQ == SEQ_POWERUP);
  assign timerDone     = (cntQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= SEQ_IDLE;
      cntQ   <= '0;
    end else if (startReset) begin
      stateQ <= SEQ_RESET;
      cntQ   <= CNT_LOAD;
    end else if (startPowerUp) begin
      stateQ <= SEQ_POWERUP;
      cntQ   <= CNT_LOAD;
    end else if (cancelPowerUp) begin
      stateQ <= SEQ_IDLE;
      cntQ   <= '0;
    end else if (stateQ != SEQ_IDLE) begin
      if (timerDone) stateQ <= SEQ_IDLE;
      else           cntQ   <= cntQ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusClear <= 1'b0;
      errorClear  <= 1'b0;
    end else begin
      statusClear <= startReset;
      errorClear  <= startPowerUp;
    end
  end

  assign resetActive   = (stateQ == SEQ_RESET);
  assign powerUpActive = (stateQ == SEQ_POWERUP);

  always_comb begin
    cmd.applyDefaults = startReset;
    cmd.takeWrite     = accept && !wrResetBit;
    cmd.resetActive   = resetActive;
    cmd.seqActive     = resetActive || powerUpActive;
  end
endmodule

// File: rtl/phyctl_regs.sv
module phyctl_regs
  import phyctl_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] phyAddr,
  input  regCmd_t           cmd,
  input  logic [REG_W-1:0]  wrData,
  input  logic              rdEn,
  output logic [REG_W-1:0]  rdData,
  output logic              pdNow,
  output logic              loopbackEn,
  output logic              powerDownEn,
  output logic              isolateEn,
  output logic              fullDuplexEn,
  output logic              colTestEn,
  output logic              lineEnable,
  output logic              miiEnable,
  output logic              colDetectEn
);
  logic [REG_W-1:0] defWord;
  logic [REG_W-1:0] storeQ;
  logic [REG_W-1:0] liveWord;
  logic             dataUp;

  always_comb begin
    defWord            = '0;
    defWord[B_ISOLATE] = (phyAddr == '0);
  end

  // one flop per writable bit, fixed value elsewhere
  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (WR_MASK[b]) begin : g_rw
      always_ff @(posedge clk) begin
        if (!rstN || cmd.applyDefaults) storeQ[b] <= defWord[b];
        else if (cmd.takeWrite)         storeQ[b] <= wrData[b];
      end
    end else begin : g_fixed
      assign storeQ[b] = ONE_MASK[b];
    end
  end

  always_comb begin
    liveWord          = storeQ;
    liveWord[B_RESET] = cmd.resetActive;
  end

  assign rdData = rdEn ? liveWord : '0;

  assign loopbackEn   = storeQ[B_LOOP];
  assign powerDownEn  = storeQ[B_PDOWN];
  assign isolateEn    = storeQ[B_ISOLATE];
  assign fullDuplexEn = storeQ[B_DUPLEX];
  assign colTestEn    = storeQ[B_COLTEST];
  assign pdNow        = storeQ[B_PDOWN];

  assign dataUp      = !storeQ[B_PDOWN] && !cmd.seqActive;
  assign lineEnable  = dataUp && !storeQ[B_LOOP];
  assign miiEnable   = dataUp && !storeQ[B_ISOLATE];
  assign colDetectEn = dataUp && (!storeQ[B_LOOP] || storeQ[B_COLTEST]);
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
  import phyctl_pkg::*;
#(
  parameter int ADDR_W       = 5,
  parameter int TIMER_CYCLES = 50_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic              mgmtWrEn,
  input  logic [15:0]       mgmtWrData,
  input  logic              mgmtRdEn,
  output logic [15:0]       mgmtRdData,
  output logic              busy,
  output logic              loopbackEn,
  output logic              powerDownEn,
  output logic              isolateEn,
  output logic              fullDuplexEn,
  output logic              colTestEn,
  output logic              lineEnable,
  output logic              miiEnable,
  output logic              colDetectEn,
  output logic              statusClear,
  output logic              errorClear
);
  regCmd_t cmd;
  logic    pdNow;
  logic    resetActive;
  logic    powerUpActive;

  phyctl_seq #(.TIMER_CYCLES(TIMER_CYCLES)) i_seq (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (mgmtWrEn),
    .wrResetBit   (mgmtWrData[B_RESET]),
    .wrPdBit      (mgmtWrData[B_PDOWN]),
    .pdNow        (pdNow),
    .cmd          (cmd),
    .resetActive  (resetActive),
    .powerUpActive(powerUpActive),
    .statusClear  (statusClear),
    .errorClear   (errorClear)
  );

  phyctl_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk         (clk),
    .rstN        (rstN),
    .phyAddr     (phyAddr),
    .cmd         (cmd),
    .wrData      (mgmtWrData),
    .rdEn        (mgmtRdEn),
    .rdData      (mgmtRdData),
    .pdNow       (pdNow),
    .loopbackEn  (loopbackEn),
    .powerDownEn (powerDownEn),
    .isolateEn   (isolateEn),
    .fullDuplexEn(fullDuplexEn),
    .colTestEn   (colTestEn),
    .lineEnable  (lineEnable),
    .miiEnable   (miiEnable),
    .colDetectEn (colDetectEn)
  );

  assign busy = resetActive || powerUpActive;
endmodule

// File: rtl/phyctl_checker.sv
module phyctl_checker #(
  parameter int TIMER_CYCLES = 50_000_000
) (
  input logic        clk,
  input logic        rstN,
  input logic        mgmtWrEn,
  input logic [15:0] mgmtWrData,
  input logic        mgmtRdEn,
  input logic [15:0] mgmtRdData,
  input logic        busy,
  input logic        resetActive,
  input logic        loopbackEn,
  input logic        powerDownEn,
  input logic        isolateEn,
  input logic        fullDuplexEn,
  input logic        colTestEn,
  input logic        lineEnable,
  input logic        miiEnable,
  input logic        colDetectEn,
  input logic        statusClear,
  input logic        errorClear
);
  int busyRun;

  always_ff @(posedge clk) begin
    if (!rstN || !busy)                busyRun <= 0;
    else if (statusClear || errorClear) busyRun <= 1;
    else                                busyRun <= busyRun + 1;
  end

  // R2: interval never outlasts the timer
  always_ff @(posedge clk) begin
    if (rstN) a_r2_busy_bounded: assert (busyRun <= TIMER_CYCLES);
  end

  a_r2_reset_start: assert property (@(posedge clk) disable iff (!rstN)
    (mgmtWrEn && !resetActive && mgmtWrData[15]) |=> (busy && statusClear && resetActive));

  a_r3_write_locked: assert property (@(posedge clk) disable iff (!rstN)
    (resetActive && mgmtWrEn) |=>
      $stable({loopbackEn, powerDownEn, isolateEn, fullDuplexEn, colTestEn}));

  a_r4_fixed_bits: assert property (@(posedge clk) disable iff (!rstN)
    mgmtRdEn |-> (mgmtRdData[13] && !mgmtRdData[12] && !mgmtRdData[9] && mgmtRdData[6:0] == 7'd0));

  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !mgmtRdEn |-> (mgmtRdData == 16'h0000));

  a_r7_pd_quiet: assert property (@(posedge clk) disable iff (!rstN)
    powerDownEn |-> (!lineEnable && !miiEnable && !colDetectEn));

  a_r7_powerup_quiet: assert property (@(posedge clk) disable iff (!rstN)
    errorClear |-> (busy && !lineEnable && !miiEnable));

  a_r8_status_single: assert property (@(posedge clk) disable iff (!rstN)
    statusClear |=> !statusClear);

  a_r8_error_single: assert property (@(posedge clk) disable iff (!rstN)
    errorClear |=> !errorClear);

  a_r9_loop_line: assert property (@(posedge clk) disable iff (!rstN)
    loopbackEn |-> !lineEnable);

  a_r9_loop_col: assert property (@(posedge clk) disable iff (!rstN)
    (loopbackEn && !colTestEn) |-> !colDetectEn);

  a_r10_isolate: assert property (@(posedge clk) disable iff (!rstN)
    isolateEn |-> !miiEnable);
endmodule

bind phy_ctrl_reg phyctl_checker #(.TIMER_CYCLES(TIMER_CYCLES)) u_phyctl_checker (.*);

// File: tb/test_phy_ctrl_reg.sv
`timescale 1ns/1ps
module test_phy_ctrl_reg;
  localparam int ADDR_W = 5;
  localparam int N      = 6;
  localparam logic [15:0] WMASK = 16'h4D80;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] phyAddr = 5'd5;
  logic              mgmtWrEn = 1'b0;
  logic [15:0]       mgmtWrData = '0;
  logic              mgmtRdEn = 1'b0;
  logic [15:0]       mgmtRdData;
  logic busy, loopbackEn, powerDownEn, isolateEn, fullDuplexEn, colTestEn;
  logic lineEnable, miiEnable, colDetectEn, statusClear, errorClear;

  int testsRun = 0;
  int testsFailed = 0;

  phy_ctrl_reg #(.ADDR_W(ADDR_W), .TIMER_CYCLES(N)) i_phy_ctrl_reg (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    mgmtWrEn = 1'b1; mgmtWrData = d;
    @(negedge clk);
    mgmtWrEn = 1'b0; mgmtWrData = '0;
  endtask

  task automatic rd(output logic [15:0] v);
    mgmtRdEn = 1'b1; #1;
    v = mgmtRdData;
    mgmtRdEn = 1'b0; #1;
  endtask

  task automatic hardReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 4 * N && busy; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    testsFailed++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [15:0] v;
    @(negedge clk);

    // R1: strap sweep of the isolate default
    for (int a = 0; a < 32; a++) begin
      phyAddr = ADDR_W'(a);
      hardReset();
      rd(v);
      chk("R1", v, (a == 0) ? 16'h2400 : 16'h2000);
    end
    phyAddr = 5'd5;
    hardReset();
    chk("R1 busy", {15'd0, busy}, 16'd0);

    // R5: no read strobe means zero
    chk("R5", mgmtRdData, 16'h0000);

    // R4 R6: every pattern with bit 15 clear
    for (int p = 0; p < 32768; p++) begin
      logic [15:0] w;
      w = 16'(p);
      wr(w);
      rd(v);
      chk("R4/R6 read", v, (w & WMASK) | 16'h2000);
      chk("R6 outs", {11'd0, loopbackEn, powerDownEn, isolateEn, fullDuplexEn, colTestEn},
          {11'd0, w[14], w[11], w[10], w[8], w[7]});
    end
    wr(16'h0000);
    waitIdle();
    chk("R5 idle", mgmtRdData, 16'h0000);

    // R2 R8 R3: soft reset with stored controls
    wr(16'h4D80);
    waitIdle();
    wr(16'hC100);
    rd(v);
    chk("R2 bit15 first", v, 16'hA000);
    chk("R2 busy first", {15'd0, busy}, 16'd1);
    chk("R8 statusClear pulse", {15'd0, statusClear}, 16'd1);
    chk("R2 defaults", {11'd0, loopbackEn, powerDownEn, isolateEn, fullDuplexEn, colTestEn}, 16'd0);
    @(negedge clk);
    chk("R8 statusClear single", {15'd0, statusClear}, 16'd0);
    wr(16'h4180);
    repeat (N - 3) @(negedge clk);
    rd(v);
    chk("R2 bit15 last", v, 16'hA000);
    chk("R2 busy last", {15'd0, busy}, 16'd1);
    @(negedge clk);
    rd(v);
    chk("R2 cleared", v, 16'h2000);
    chk("R3 locked write", {11'd0, loopbackEn, powerDownEn, isolateEn, fullDuplexEn, colTestEn}, 16'd0);
    chk("R2 busy done", {15'd0, busy}, 16'd0);

    // R2 R1: soft reset restores the isolate strap at address zero
    phyAddr = 5'd0;
    wr(16'h8000);
    waitIdle();
    rd(v);
    chk("R2 strap default", v, 16'h2400);
    phyAddr = 5'd5;
    wr(16'h0000);

    // R7 R8: power-down and timed power-up
    wr(16'h0800);
    chk("R7 pd quiet", {13'd0, lineEnable, miiEnable, colDetectEn}, 16'd0);
    chk("R7 pd no busy", {15'd0, busy}, 16'd0);
    wr(16'h0000);
    chk("R8 errorClear pulse", {15'd0, errorClear}, 16'd1);
    chk("R7 powerup busy", {15'd0, busy}, 16'd1);
    chk("R7 powerup quiet", {13'd0, lineEnable, miiEnable, colDetectEn}, 16'd0);
    @(negedge clk);
    chk("R8 errorClear single", {15'd0, errorClear}, 16'd0);
    repeat (N - 2) @(negedge clk);
    chk("R7 last cycle", {12'd0, busy, lineEnable, miiEnable, colDetectEn}, 16'b1000);
    @(negedge clk);
    chk("R7 up again", {12'd0, busy, lineEnable, miiEnable, colDetectEn}, 16'b0111);

    // R9: loopback and collision test
    wr(16'h4000);
    chk("R9 loopback", {13'd0, lineEnable, miiEnable, colDetectEn}, 16'b010);
    wr(16'h4080);
    chk("R9 loop+coltest", {13'd0, lineEnable, miiEnable, colDetectEn}, 16'b011);

    // R10: isolate
    wr(16'h0400);
    chk("R10 isolate", {13'd0, lineEnable, miiEnable, colDetectEn}, 16'b101);
    wr(16'h0000);
    chk("R10 released", {13'd0, lineEnable, miiEnable, colDetectEn}, 16'b111);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule